// File: doc/BRIEF.md
# Multiplexed Receive Character Silo

This block is the shared receive queue of a 16-line asynchronous terminal multiplexer. A line receiver front end presents one character at a time on a strobe, together with the index of the line it arrived on and its parity and framing error flags. The block tags the character with its line index and stores it in a 64-entry first-in first-out silo. Host software sees the oldest entry through a 16-bit receive character register. The valid flag sits in the sign bit, so software can drain the silo with a loop that runs while the register reads as negative. Each read of that register removes the entry it returned.

A programmable alarm level sets the receive interrupt flag once the silo holds that many characters. The flag drives the interrupt request when the receive interrupt enable is set. When the silo is full, an arriving character is discarded. The next character that is accepted carries an overrun mark. A maintenance bit drives a loopback enable towards the line front ends. With maintenance set, software can force the interrupt flag, which lets a probe routine raise an interrupt without any traffic. A master clear bit returns the whole block to its idle state.

Top module: `mux_rx_silo`

## Requirements
- R1: After reset the silo is empty, every register reads 0 (including the receive character register, whose bit 15 is clear), and `rx_irq` and `loop_en` are low.
- R2: With `bus_sel`=1, `bus_rdata` shows the oldest entry. Bit 15 is 1 when data is present, bit 14 is overrun, bit 13 is framing error, bit 12 is parity error, bits 11:8 are the line index and bits 7:0 are the character. Entries come out in arrival order.
- R3: A read (`bus_rd`) with `bus_sel`=1 removes the head entry at that clock edge. A read of the empty silo returns 0 and changes nothing.
- R4: The silo holds 64 entries. A character strobed while 64 entries are held is discarded, even if a read removes an entry in the same cycle.
- R5: After a discard, the next accepted character has bit 14 set. Later characters do not, unless another discard occurs.
- R6: With `bus_sel`=2, a write stores the alarm level from bits 6:0 and a read returns it in bits 6:0, with the other bits 0.
- R7: With `bus_sel`=0, the control register reads receive enable at bit 6, the receive flag at bit 7 and maintenance at bit 9. Bit 11 (master clear) always reads 0. The flag is 1 while the silo is non-empty and its occupancy is at least the alarm level.
- R8: `rx_irq` is high exactly when the receive flag and the receive enable are both 1.
- R9: A control write sets enable from bit 6 and maintenance from bit 9. Maintenance drives `loop_en`. A control write with bits 7 and 9 both set forces the flag to 1. Any later control write without both bits clears the force.
- R10: A control write with bit 11 set is a master clear. It empties the silo and clears enable, maintenance, force, alarm level and any pending overrun mark. The other bits of that write and a character strobed in the same cycle are ignored.
- R11: When a character arrives in the same cycle as a read of a non-full silo, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | A character is offered this cycle |
| rx_line | input | 4 | Line index of the offered character |
| rx_char | input | 8 | Character value |
| rx_perr | input | 1 | Parity error on the character |
| rx_ferr | input | 1 | Framing error (break) on the character |
| bus_sel | input | 2 | Register select: 0 control, 1 receive character, 2 alarm level |
| bus_rd | input | 1 | Read strobe, removes the head entry when selecting 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register, combinational from state |
| rx_irq | output | 1 | Receive interrupt request |
| loop_en | output | 1 | Maintenance loopback enable towards the line front ends |

## Verification
The assertions assume that the bus selects one register per cycle, so a receive read and a master clear never fall in the same cycle. They also assume that `bus_sel`=3 is never written. The bench keeps to this by driving the bus through tasks that issue one access at a time. It may still combine an access with a character strobe, which is how the full-silo read and master clear collisions are reached. Alarm levels written by the bench stay within 0 to 64, so the flag comparison never depends on bits the register drops.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 4;
  localparam int WORD_W = 16;

  // control register bit positions
  localparam int B_RIE = 6;
  localparam int B_RI  = 7;
  localparam int B_MM  = 9;
  localparam int B_MC  = 11;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] chr;
  } silo_ent_t;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_RCR  = 2'd1,
    SEL_ALM  = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  // flag condition: non-empty and occupancy at or above the level
  function automatic logic alarm_hit(input int unsigned cnt, input int unsigned lvl);
    return (cnt != 0) && (cnt >= lvl);
  endfunction

  function automatic logic [WORD_W-1:0] rcr_word(input logic vld, input silo_ent_t e);
    return vld ? {1'b1, e} : '0;
  endfunction

  function automatic logic [WORD_W-1:0] csr_word(input logic rie, input logic ri, input logic mm);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_RIE] = rie;
    w[B_RI]  = ri;
    w[B_MM]  = mm;
    return w;
  endfunction
endpackage

// File: rtl/mrs_fifo.sv
module mrs_fifo
  import mrs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  silo_ent_t     push_ent,
  input  logic          pop,
  output silo_ent_t     head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  silo_ent_t         mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              push_acc, pop_ok;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_acc = push_req && !full;
  assign pop_ok   = pop && !empty;
  assign head     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_acc) wptr <= wptr + 1'b1;
      if (pop_ok)   rptr <= rptr + 1'b1;
      case ({push_acc, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop && !clr) |=> (count == $past(count))); // R4
  AST_PUSH_POP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop && !full && !empty && !clr) |=> (count == $past(count))); // R11
endmodule

// File: rtl/mrs_regs.sv
module mrs_regs
  import mrs_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr,
  input  logic              wr_alm,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CW-1:0]     count,
  output logic              mc,
  output logic              rie,
  output logic              mm,
  output logic              ri,
  output logic [CW-1:0]     alarm,
  output logic              irq
);
  logic force_q;
  logic lvl_hit;

  assign mc      = wr_csr && wdata[B_MC];
  assign lvl_hit = alarm_hit(32'(count), 32'(alarm));
  assign ri      = force_q || lvl_hit;
  assign irq     = rie && ri;

  always_ff @(posedge clk) begin
    if (!rst_n || mc) begin
      rie     <= 1'b0;
      mm      <= 1'b0;
      force_q <= 1'b0;
      alarm   <= '0;
    end else begin
      if (wr_csr) begin
        rie     <= wdata[B_RIE];
        mm      <= wdata[B_MM];
        force_q <= wdata[B_RI] && wdata[B_MM];
      end
      if (wr_alm) alarm <= wdata[CW-1:0];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  AST_MC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mc |=> (alarm == '0 && !rie && !mm && !irq)); // R10
  AST_FORCE_NEEDS_MM: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> mm); // R9
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import mrs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_stb,
  input  logic [LINE_W-1:0] rx_line,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic [1:0]        bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              rx_irq,
  output logic              loop_en
);
  logic          mc, rie, mm, ri;
  logic [CW-1:0] alarm, count;
  logic          empty, full;
  logic          wr_csr, wr_alm, pop, push_req;
  logic          ovr_pend;
  silo_ent_t     head, in_ent;

  assign wr_csr   = bus_wr && (bus_sel == SEL_CSR);
  assign wr_alm   = bus_wr && (bus_sel == SEL_ALM);
  assign pop      = bus_rd && (bus_sel == SEL_RCR) && !empty;
  assign push_req = rx_stb && !mc;

  always_comb begin
    in_ent.ovr  = ovr_pend;
    in_ent.ferr = rx_ferr;
    in_ent.perr = rx_perr;
    in_ent.line = rx_line;
    in_ent.chr  = rx_char;
  end

  // overrun mark waiting for the next accepted character
  always_ff @(posedge clk) begin
    if (!rst_n || mc)        ovr_pend <= 1'b0;
    else if (push_req)       ovr_pend <= full;
  end

  mrs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mc),
    .push_req (push_req),
    .push_ent (in_ent),
    .pop      (pop),
    .head     (head),
    .count    (count),
    .empty    (empty),
    .full     (full)
  );

  mrs_regs #(.CW(CW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_csr (wr_csr),
    .wr_alm (wr_alm),
    .wdata  (bus_wdata),
    .count  (count),
    .mc     (mc),
    .rie    (rie),
    .mm     (mm),
    .ri     (ri),
    .alarm  (alarm),
    .irq    (rx_irq)
  );

  assign loop_en = mm;

  always_comb begin
    case (bus_sel)
      SEL_CSR: bus_rdata = csr_word(rie, ri, mm);
      SEL_RCR: bus_rdata = rcr_word(!empty, head);
      SEL_ALM: bus_rdata = WORD_W'(alarm);
      default: bus_rdata = '0;
    endcase
  end

  AST_OVR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && full && !mc) |=> ovr_pend); // R5
  AST_OVR_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && !full && !mc) |=> !ovr_pend); // R5
  AST_MC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    mc |=> empty); // R10
endmodule

// File: tb/tb_mux_rx_silo.sv
`timescale 1ns/1ps
module tb_mux_rx_silo;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_stb, rx_perr, rx_ferr;
  logic [3:0]  rx_line;
  logic [7:0]  rx_char;
  logic [1:0]  bus_sel;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rx_irq, loop_en;

  always #2.5 clk = ~clk;

  mux_rx_silo dut (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_line(rx_line), .rx_char(rx_char),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_irq(rx_irq), .loop_en(loop_en)
  );

  // behavioural model
  logic [14:0] q[$];
  bit          m_ovr, m_rie, m_mm, m_force;
  int          m_alarm;
  int          checks = 0, fails = 0;
  string       cur_req = "R1";
  bit          done = 0;

  function automatic bit m_ri();
    return m_force || (q.size() != 0 && q.size() >= m_alarm);
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] s);
    logic [15:0] w;
    w = '0;
    case (s)
      2'd0: begin w[6] = m_rie; w[7] = m_ri(); w[9] = m_mm; end
      2'd1: if (q.size() != 0) w = {1'b1, q[0]};
      2'd2: w = 16'(m_alarm);
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      q.delete(); m_ovr = 0; m_rie = 0; m_mm = 0; m_force = 0; m_alarm = 0;
    end else if (bus_wr && bus_sel == 2'd0 && bus_wdata[11]) begin
      q.delete(); m_ovr = 0; m_rie = 0; m_mm = 0; m_force = 0; m_alarm = 0;
    end else begin
      int sz;
      sz = q.size();
      if (bus_rd && bus_sel == 2'd1 && sz != 0) void'(q.pop_front());
      if (rx_stb) begin
        if (sz >= DEPTH) m_ovr = 1;
        else begin
          q.push_back({m_ovr, rx_ferr, rx_perr, rx_line, rx_char});
          m_ovr = 0;
        end
      end
      if (bus_wr && bus_sel == 2'd0) begin
        m_rie = bus_wdata[6]; m_mm = bus_wdata[9];
        m_force = bus_wdata[7] && bus_wdata[9];
      end
      if (bus_wr && bus_sel == 2'd2) m_alarm = int'(bus_wdata[6:0]);
    end
  endtask

  // drives are set by the caller at the negative edge
  task automatic cycle();
    #1;
    if (rst_n) begin
      chk(bus_rdata, m_read(bus_sel), "rdata");
      chk({15'd0, rx_irq}, {15'd0, m_rie && m_ri()}, "rx_irq R8");
      chk({15'd0, loop_en}, {15'd0, m_mm}, "loop_en R9");
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rx_stb = 0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic push(input logic [3:0] ln, input logic [7:0] c, input logic pe, input logic fe);
    rx_stb = 1; rx_line = ln; rx_char = c; rx_perr = pe; rx_ferr = fe;
    cycle();
  endtask

  task automatic rd_rcr();
    bus_sel = 2'd1; bus_rd = 1;
    cycle();
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    bus_sel = s; bus_wr = 1; bus_wdata = d;
    cycle();
  endtask

  task automatic look(input logic [1:0] s);
    bus_sel = s;
    cycle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_stb = 0; rx_line = '0; rx_char = '0; rx_perr = 0; rx_ferr = 0;
    bus_sel = 2'd0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle();
    rst_n = 1;

    // R1 reset state
    cur_req = "R1";
    look(2'd0); look(2'd1); look(2'd2); look(2'd3);

    // R2 entry layout and order
    cur_req = "R2";
    push(4'd3, 8'h41, 0, 0);
    push(4'd15, 8'hA5, 1, 0);
    push(4'd0, 8'h00, 0, 1);
    look(2'd1);
    rd_rcr(); rd_rcr(); rd_rcr();

    // R3 read of empty silo
    cur_req = "R3";
    rd_rcr(); look(2'd1);
    push(4'd7, 8'h5A, 1, 1);
    rd_rcr(); look(2'd1);

    // R11 simultaneous arrival and read
    cur_req = "R11";
    push(4'd1, 8'h11, 0, 0);
    bus_sel = 2'd1; bus_rd = 1; rx_stb = 1; rx_line = 4'd2; rx_char = 8'h22; cycle();
    rd_rcr(); look(2'd1);

    // R4 fill, drop when full, drop even with read
    cur_req = "R4";
    for (int i = 0; i < DEPTH; i++) push(4'(i), 8'(i + 8'h30), 0, 0);
    push(4'd9, 8'hEE, 0, 0);
    bus_sel = 2'd1; bus_rd = 1; rx_stb = 1; rx_line = 4'd9; rx_char = 8'hEF; cycle();
    for (int i = 0; i < DEPTH - 1; i++) rd_rcr();
    look(2'd1);

    // R5 overrun mark on the next accepted character only
    cur_req = "R5";
    push(4'd4, 8'h44, 0, 0);
    push(4'd5, 8'h55, 0, 0);
    rd_rcr(); rd_rcr(); look(2'd1);

    // R6 / R7 / R8 alarm level and interrupt
    cur_req = "R6";
    wr_reg(2'd2, 16'hFF83); look(2'd2);
    cur_req = "R7";
    wr_reg(2'd0, 16'h0040);
    bus_sel = 2'd0; rx_stb = 1; rx_line = 4'd1; rx_char = 8'h01; cycle();
    bus_sel = 2'd0; rx_stb = 1; rx_line = 4'd2; rx_char = 8'h02; cycle();
    bus_sel = 2'd0; rx_stb = 1; rx_line = 4'd3; rx_char = 8'h03; cycle();
    cur_req = "R8";
    look(2'd0);
    rd_rcr(); look(2'd0);
    wr_reg(2'd0, 16'h0000); look(2'd0);
    cur_req = "R7";
    wr_reg(2'd2, 16'h0000); look(2'd0);
    rd_rcr(); rd_rcr(); look(2'd0);

    // R9 forced flag in maintenance mode
    cur_req = "R9";
    wr_reg(2'd0, 16'h02C0); look(2'd0);
    wr_reg(2'd0, 16'h00C0); look(2'd0);
    wr_reg(2'd0, 16'h0240); look(2'd0);
    wr_reg(2'd0, 16'h02C0); look(2'd0);

    // R10 master clear with a strobe in the same cycle
    cur_req = "R10";
    wr_reg(2'd2, 16'd5);
    push(4'd6, 8'h66, 0, 0);
    bus_sel = 2'd0; bus_wr = 1; bus_wdata = 16'h0AC0; rx_stb = 1; rx_line = 4'd8; rx_char = 8'h88; cycle();
    look(2'd0); look(2'd1); look(2'd2);
    for (int i = 0; i < DEPTH + 1; i++) push(4'd2, 8'(i), 0, 0);
    wr_reg(2'd0, 16'h0800);
    push(4'd3, 8'h33, 0, 0);
    rd_rcr(); look(2'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule